// File: doc/BRIEF.md
# Register-Controlled SPI Master Port

This block is a serial port core that runs as a full-duplex SPI master with 8-bit characters. Software drives it through a small 32-bit register file on a simple read/write strobe bus. It can set the clock mode and divisor, enable or reset the transmit and receive halves on their own, queue one byte at a time, and collect each received byte from a holding register. The core drives the serial clock, the data-out line and an active-low chip select, and samples the data-in line. A single level interrupt reports the unmasked status flags.

Each byte written to the transmit holding register is shifted out MSB first. A byte is shifted in at the same time and lands in the receive holding register, where a ready flag marks it. If a second byte completes before software has read the first, an overrun flag is raised and stays set until the receiver is reset. The serial clock period equals the baud divisor in input clock cycles, with a floor of six cycles. A divisor of zero keeps the port idle. Chip select stays low across bytes that follow without a gap, and rises one serial clock period after the last byte.

Top module: `spi_port_master`

## Requirements
- R1: After reset the status register (0x14) reads 0, the divisor register (0x20) reads 0, irq is low, cs_n is high, sck is low, and the identity register (0xFC) reads 32'h0003_0100.
- R2: The mode register (0x04) reads back only its defined bits, which are mask 32'h0005_81CF: [3:0] operating mode, [7:6] character length, [8] phase, [15] loopback, [16] polarity and [18] clock output enable. The divisor register keeps its low 16 bits.
- R3: Control register (0x00) strobes: bit 4 enables receive, bit 5 disables receive, bit 6 enables transmit, bit 7 disables transmit. A disable wins over an enable in the same write. While transmit is disabled, status bit 1 (transmitter ready) is 0 and writes to the transmit holding register (0x1C) are dropped.
- R4: A byte written to 0x1C is shifted out MSB first while a byte is shifted in. The received byte appears at 0x18 with status bit 0 (receive ready) set. Reading 0x18 clears bit 0.
- R5: One serial clock period lasts max(divisor, 6) input cycles. With divisor 0 no transfer starts, and the byte stays pending with status bit 1 at 0 until a divisor is written.
- R6: sck idles at the polarity bit. With phase 0, data-in is sampled on the first clock edge of each bit. With phase 1, data-out changes on the first edge and data-in is sampled on the second edge.
- R7: With loopback set, the received byte equals the transmitted byte and miso is ignored.
- R8: A byte that completes while receive ready is still set raises status bit 5 (overrun) and replaces the held byte. Overrun survives a read of 0x18 and is cleared by control bit 2 (receiver reset), which also clears receive ready.
- R9: cs_n falls when a byte starts and stays low through a byte queued during the previous one. It rises one serial clock period after the last bit, so one byte holds cs_n low for 9 periods and two chained bytes for 17 periods.
- R10: Writing 1s to 0x08 unmasks status bits 0, 1 and 5, and writing 1s to 0x0C masks them. Zero bits change nothing. irq is high exactly when an unmasked status bit is set.
- R11: Control bit 3 (transmitter reset) aborts a byte in flight, empties the holding register and raises cs_n. No byte is received, and later transfers still work.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (read side effects) |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low chip select |
| irq | output | 1 | Level interrupt |

## Verification
The bench acts as an SPI slave and exercises all four clock modes with random bytes and divisors. It checks the slave's received byte, the byte in the receive holding register, and the exact number of cycles cs_n stays low. A swapped phase would garble both data streams, and a wrong divisor floor or a missing tail period would change the cs_n low time. Directed cases cover a zero divisor, where a design that started anyway would lower cs_n. They also cover two chained bytes, where a design that released chip select between bytes would cut the low time, and overrun stickiness across a data read. A transmitter reset mid-byte must leave cs_n high and no byte received.

// File: rtl/spi_port_pkg.sv
// Shared constants for the SPI master port: register offsets, control strobe
// positions, mode fields and status bits. Assumes an 8-bit byte-offset bus.
package spi_port_pkg;
    localparam int ADDR_W = 8;
    localparam int BUS_W  = 32;

    localparam logic [ADDR_W-1:0] OFS_CTRL = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_MODE = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_IEN  = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_IDIS = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_STAT = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_RXD  = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_TXD  = 8'h1C;
    localparam logic [ADDR_W-1:0] OFS_BAUD = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_VER  = 8'hFC;

    localparam int CB_RX_RST = 2;
    localparam int CB_TX_RST = 3;
    localparam int CB_RX_ON  = 4;
    localparam int CB_RX_OFF = 5;
    localparam int CB_TX_ON  = 6;
    localparam int CB_TX_OFF = 7;

    localparam int MB_PHASE = 8;
    localparam int MB_LOOP  = 15;
    localparam int MB_POL   = 16;
    localparam int MB_CKOUT = 18;
    localparam logic [BUS_W-1:0] MODE_KEEP = 32'h0005_81CF;

    localparam int STAT_W   = 6;
    localparam int SB_RXRDY = 0;
    localparam int SB_TXRDY = 1;
    localparam int SB_OVR   = 5;
    localparam logic [STAT_W-1:0] IRQ_SRC = 6'b10_0011;

    typedef enum logic [1:0] {SH_IDLE, SH_SHIFT, SH_TAIL} shift_state_e;
endpackage

// File: rtl/spi_port_baud.sv
// Serial clock timebase. While run is high it counts one serial clock period
// of max(divisor, MIN_DIV) input cycles and pulses lead at the half point and
// trail at the end. Assumes run drops to 0 between transfers so each start
// begins at count zero.
module spi_port_baud #(
    parameter int DIV_W   = 16,
    parameter int MIN_DIV = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] divisor,
    output logic             lead,
    output logic             trail
);
    localparam logic [DIV_W-1:0] MIN_D = DIV_W'(MIN_DIV);
    localparam logic [DIV_W-1:0] ONE   = DIV_W'(1);

    logic [DIV_W-1:0] eff;
    logic [DIV_W-1:0] half;
    logic [DIV_W-1:0] cnt;

    // Apply the divisor floor and split the period into two halves.
    always_comb begin
        eff  = (divisor < MIN_D) ? MIN_D : divisor;
        half = eff >> 1;
    end

    // Period counter: restarts on every trail pulse and whenever idle.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= '0;
        else if (!run || trail) cnt <= '0;
        else                   cnt <= cnt + ONE;
    end

    assign lead  = run && (cnt == half - ONE);
    assign trail = run && (cnt == eff - ONE);
endmodule

// File: rtl/spi_port_shifter.sv
// Byte shift engine. It loads a byte on take, shifts MSB first on the
// timebase pulses according to phase, and samples miso (or mosi when looped).
// After the last bit it holds chip select for one tail period unless another
// byte is ready. Assumes lead and trail never fall in the same cycle.
module spi_port_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tx_rst,
    input  logic         start_ok,
    input  logic [W-1:0] load_byte,
    input  logic         phase,
    input  logic         lpbk,
    input  logic         miso,
    input  logic         lead,
    input  logic         trail,
    output logic         take,
    output logic         run,
    output logic         done,
    output logic [W-1:0] rx_byte,
    output logic         mosi,
    output logic         second_half,
    output logic         cs_n
);
    import spi_port_pkg::*;

    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] LAST    = CW'(W - 1);
    localparam logic [CW-1:0] BIT_ONE = CW'(1);

    shift_state_e state;
    logic [W-1:0]  txs;
    logic [W-1:0]  rxs;
    logic [CW-1:0] bitc;
    logic          mosi_q;
    logic          rx_in;

    // Handshake and data-path decode from the current state.
    always_comb begin
        done    = (state == SH_SHIFT) && trail && (bitc == LAST);
        take    = start_ok && ((state == SH_IDLE) || done ||
                               ((state == SH_TAIL) && trail));
        run     = (state != SH_IDLE);
        mosi    = phase ? mosi_q : txs[W-1];
        rx_in   = lpbk ? mosi : miso;
        rx_byte = phase ? {rxs[W-2:0], rx_in} : rxs;
    end

    // Sequencing of load, per-edge shifting, tail hold and chip select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= SH_IDLE;
            txs         <= '0;
            rxs         <= '0;
            bitc        <= '0;
            mosi_q      <= 1'b0;
            second_half <= 1'b0;
            cs_n        <= 1'b1;
        end else if (tx_rst) begin
            state       <= SH_IDLE;
            bitc        <= '0;
            second_half <= 1'b0;
            cs_n        <= 1'b1;
        end else if (take) begin
            state       <= SH_SHIFT;
            txs         <= load_byte;
            bitc        <= '0;
            second_half <= 1'b0;
            cs_n        <= 1'b0;
        end else if (state == SH_SHIFT) begin
            if (lead) begin
                second_half <= 1'b1;
                if (phase) begin
                    mosi_q <= txs[W-1];
                    txs    <= txs << 1;
                end else begin
                    rxs <= {rxs[W-2:0], rx_in};
                end
            end
            if (trail) begin
                second_half <= 1'b0;
                if (phase) rxs <= {rxs[W-2:0], rx_in};
                else       txs <= txs << 1;
                bitc <= bitc + BIT_ONE;
                if (bitc == LAST) state <= SH_TAIL;
            end
        end else if ((state == SH_TAIL) && trail) begin
            state <= SH_IDLE;
            cs_n  <= 1'b1;
        end
    end
endmodule

// File: rtl/spi_port_master.sv
// Register-controlled SPI master port. It decodes the register file, holds
// one transmit byte and one received byte, tracks overrun, and drives a level
// interrupt from the masked status. Assumes single-cycle bus strobes with
// combinational read data and read side effects on bus_rd.
module spi_port_master #(
    parameter int          DIV_W      = 16,
    parameter int          MIN_DIV    = 6,
    parameter logic [31:0] VERSION_ID = 32'h0003_0100
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        sck,
    output logic        mosi,
    input  logic        miso,
    output logic        cs_n,
    output logic        irq
);
    import spi_port_pkg::*;

    localparam int CHAR_W = 8;

    logic [BUS_W-1:0]  mode_q;
    logic [DIV_W-1:0]  div_q;
    logic              tx_en, rx_en;
    logic [STAT_W-1:0] mask_q, stat;
    logic [CHAR_W-1:0] hold_q, rx_data, rx_byte;
    logic              hold_full, rx_rdy, ovr_q, txrdy;
    logic              wr_ctrl, rx_rst, tx_rst, rhr_rd, txd_wr;
    logic              take, run, done, lead, trail, second_half;
    logic              start_ok, sck_pol;

    // Bus decode of write strobes and read side effects.
    always_comb begin
        wr_ctrl  = bus_wr && (bus_addr == OFS_CTRL);
        rx_rst   = wr_ctrl && bus_wdata[CB_RX_RST];
        tx_rst   = wr_ctrl && bus_wdata[CB_TX_RST];
        txd_wr   = bus_wr && (bus_addr == OFS_TXD) && tx_en && !hold_full;
        rhr_rd   = bus_rd && (bus_addr == OFS_RXD);
        start_ok = hold_full && tx_en && (div_q != '0);
        txrdy    = tx_en && !hold_full;
        sck_pol  = mode_q[MB_POL];
    end

    // Configuration registers: mode, divisor, interrupt mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            div_q  <= '0;
            mask_q <= '0;
        end else if (bus_wr) begin
            if (bus_addr == OFS_MODE) mode_q <= bus_wdata & MODE_KEEP;
            if (bus_addr == OFS_BAUD) div_q  <= bus_wdata[DIV_W-1:0];
            if (bus_addr == OFS_IEN)  mask_q <= mask_q | (bus_wdata[STAT_W-1:0] & IRQ_SRC);
            if (bus_addr == OFS_IDIS) mask_q <= mask_q & ~bus_wdata[STAT_W-1:0];
        end
    end

    // Enable strobes; a disable bit wins over an enable bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_en <= 1'b0;
            rx_en <= 1'b0;
        end else if (wr_ctrl) begin
            if (bus_wdata[CB_TX_OFF])     tx_en <= 1'b0;
            else if (bus_wdata[CB_TX_ON]) tx_en <= 1'b1;
            if (bus_wdata[CB_RX_OFF])     rx_en <= 1'b0;
            else if (bus_wdata[CB_RX_ON]) rx_en <= 1'b1;
        end
    end

    // Transmit holding register: filled by the bus, emptied by the engine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q    <= '0;
            hold_full <= 1'b0;
        end else if (tx_rst || take) begin
            hold_full <= 1'b0;
        end else if (txd_wr) begin
            hold_q    <= bus_wdata[CHAR_W-1:0];
            hold_full <= 1'b1;
        end
    end

    // Receive holding register with ready and sticky overrun flags.
    always_ff @(posedge clk) begin
        if (!rst_n || rx_rst) begin
            rx_data <= '0;
            rx_rdy  <= 1'b0;
            ovr_q   <= 1'b0;
        end else if (done && rx_en) begin
            rx_data <= rx_byte;
            rx_rdy  <= 1'b1;
            if (rx_rdy && !rhr_rd) ovr_q <= 1'b1;
        end else if (rhr_rd) begin
            rx_rdy <= 1'b0;
        end
    end

    // Status vector and interrupt from unmasked sources.
    always_comb begin
        stat           = '0;
        stat[SB_RXRDY] = rx_rdy;
        stat[SB_TXRDY] = txrdy;
        stat[SB_OVR]   = ovr_q;
        irq            = |(stat & mask_q);
    end

    // Read data multiplexer.
    always_comb begin
        case (bus_addr)
            OFS_MODE: bus_rdata = mode_q;
            OFS_STAT: bus_rdata = {{(BUS_W-STAT_W){1'b0}}, stat};
            OFS_RXD:  bus_rdata = {{(BUS_W-CHAR_W){1'b0}}, rx_data};
            OFS_BAUD: bus_rdata = {{(BUS_W-DIV_W){1'b0}}, div_q};
            OFS_VER:  bus_rdata = VERSION_ID;
            default:  bus_rdata = '0;
        endcase
    end

    assign sck = mode_q[MB_CKOUT] ? (sck_pol ^ second_half) : sck_pol;

    spi_port_baud #(.DIV_W(DIV_W), .MIN_DIV(MIN_DIV)) u_baud (
        .clk(clk), .rst_n(rst_n), .run(run), .divisor(div_q),
        .lead(lead), .trail(trail)
    );

    spi_port_shifter #(.W(CHAR_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .tx_rst(tx_rst), .start_ok(start_ok),
        .load_byte(hold_q), .phase(mode_q[MB_PHASE]), .lpbk(mode_q[MB_LOOP]),
        .miso(miso), .lead(lead), .trail(trail), .take(take), .run(run),
        .done(done), .rx_byte(rx_byte), .mosi(mosi),
        .second_half(second_half), .cs_n(cs_n)
    );
endmodule

// File: rtl/spi_port_master_chk.sv
// Property checker for spi_port_master, bound to every instance. It observes
// ports and a few internal handshake signals; it drives nothing.
module spi_port_master_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       sck,
    input logic       pol,
    input logic       tx_en,
    input logic       txrdy,
    input logic       ovr,
    input logic       rx_rst,
    input logic       rx_rdy,
    input logic       rhr_rd,
    input logic       done,
    input logic       irq,
    input logic [5:0] stat
);
    // R6: with chip select released the clock rests at the polarity level.
    p_sck_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (sck == pol));

    // R3: a disabled transmitter never reports ready.
    p_txrdy_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |-> !txrdy);

    // R8: overrun holds until a receiver reset strobe.
    p_ovr_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr && !rx_rst) |=> ovr);

    // R8: the receiver reset strobe clears overrun.
    p_ovr_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_rst |=> !ovr);

    // R9: a byte always completes with chip select asserted.
    p_done_cs_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !cs_n);

    // R4: a data read with no new byte arriving clears receive ready.
    p_rd_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rhr_rd && !done && !rx_rst) |=> !rx_rdy);

    // R10: the interrupt is only raised with some status bit set.
    p_irq_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (stat != 6'd0));
endmodule

bind spi_port_master spi_port_master_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .pol(sck_pol),
    .tx_en(tx_en), .txrdy(txrdy), .ovr(ovr_q), .rx_rst(rx_rst),
    .rx_rdy(rx_rdy), .rhr_rd(rhr_rd), .done(done), .irq(irq), .stat(stat)
);

// File: tb/spi_port_master_test.sv
// Bench for spi_port_master: a behavioural SPI slave on the pins, directed
// corner cases and seeded random bytes, divisors and clock modes.
module spi_port_master_test;
    localparam logic [7:0] A_CTRL = 8'h00, A_MODE = 8'h04, A_IEN = 8'h08,
                           A_IDIS = 8'h0C, A_STAT = 8'h14, A_RXD = 8'h18,
                           A_TXD = 8'h1C, A_BAUD = 8'h20, A_VER = 8'hFC;
    localparam logic [31:0] EXP_VER = 32'h0003_0100;

    logic        clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    wire  [31:0] bus_rdata;
    wire         sck, mosi, cs_n, irq;
    logic        miso = 1'b0;

    always #2 clk = ~clk;

    spi_port_master uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n), .irq(irq)
    );

    int checks = 0, errors = 0;
    bit finished = 1'b0;

    task automatic check_eq(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk); bus_rd = 1'b0;
    endtask

    // Behavioural slave: mode copy, bytes to return, bytes received.
    bit         cpha_m = 1'b0, cpol_m = 1'b0, loop_m = 1'b0;
    logic [7:0] slv_q [4];
    logic [7:0] got [4];
    logic [7:0] ssh = '0, srx = '0;
    int         ek = 0, sidx = 0, nrx = 0, cs_low = 0;

    always @(negedge cs_n) begin
        ek = 0; sidx = 0; nrx = 0;
        ssh = slv_q[0];
        if (!cpha_m) miso = ssh[7];
    end

    always @(sck) begin
        if (!cs_n) begin
            bit lead;
            lead = (ek % 2 == 0);
            if (lead != cpha_m) srx = {srx[6:0], mosi};
            if (lead == cpha_m) begin
                if (cpha_m) begin miso = ssh[7]; ssh = ssh << 1; end
                else begin ssh = ssh << 1; miso = ssh[7]; end
            end
            ek++;
            if (ek % 16 == 0) begin
                got[nrx % 4] = srx; nrx++; sidx++;
                ssh = slv_q[sidx % 4];
                if (!cpha_m) miso = ssh[7];
            end
        end
    end

    always @(negedge clk) if (!cs_n) cs_low++;

    function automatic logic [7:0] exp_rx(input logic [7:0] tx, input logic [7:0] sv);
        return loop_m ? tx : sv;
    endfunction

    task automatic set_mode(input bit pol, input bit pha, input bit lp);
        cpol_m = pol; cpha_m = pha; loop_m = lp;
        wr(A_MODE, 32'h0000_00CE | (32'(pha) << 8) | (32'(lp) << 15) |
                   (32'(pol) << 16) | (32'h1 << 18));
    endtask

    task automatic wait_frame();
        int n = 0;
        while (cs_n && n < 4000) begin @(negedge clk); n++; end
        while (!cs_n && n < 100000) begin @(negedge clk); n++; end
    endtask

    task automatic one_byte(input logic [7:0] tx, input logic [7:0] sv,
                            input int eff, input string req);
        logic [31:0] d;
        slv_q[0] = sv; slv_q[1] = sv;
        cs_low = 0;
        wr(A_TXD, {24'h0, tx});
        wait_frame();
        check_eq({req, " slave got tx byte"}, got[0], tx);
        check_eq({req, " R5 cs low = 9 periods"}, cs_low, 9 * eff);
        check_eq({req, " R6 sck idle level"}, sck, cpol_m);
        rd(A_STAT, d);
        check_eq({req, " R4 rx ready"}, d[0], 1);
        rd(A_RXD, d);
        check_eq({req, " R4 rx byte"}, d, exp_rx(tx, sv));
        rd(A_STAT, d);
        check_eq({req, " R4 ready cleared by read"}, d[0], 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int unsigned seed0;
        seed0 = $urandom(32'd2024);
        for (int i = 0; i < 4; i++) slv_q[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check_eq("R1 cs_n", cs_n, 1);
        check_eq("R1 irq", irq, 0);
        check_eq("R1 sck", sck, 0);
        rd(A_STAT, d); check_eq("R1 status", d, 0);
        rd(A_BAUD, d); check_eq("R1 divisor", d, 0);
        rd(A_VER, d);  check_eq("R1 version", d, EXP_VER);

        // R2 readback masks
        wr(A_MODE, 32'hFFFF_FFFF); rd(A_MODE, d);
        check_eq("R2 mode readback", d, 32'h0005_81CF);
        wr(A_BAUD, 32'h0001_2345); rd(A_BAUD, d);
        check_eq("R2 divisor readback", d, 32'h2345);
        wr(A_BAUD, 32'h0);
        set_mode(1'b0, 1'b0, 1'b0);

        // R3 disabled writes dropped, disable wins
        wr(A_TXD, 32'hA5);
        wr(A_CTRL, (32'h1 << 6) | (32'h1 << 7));
        rd(A_STAT, d); check_eq("R3 disable wins over enable", d, 0);
        wr(A_CTRL, (32'h1 << 6) | (32'h1 << 4));
        rd(A_STAT, d); check_eq("R3 tx ready, dropped write left holding empty", d, 2);
        check_eq("R3 no transfer while disabled", cs_n, 1);

        // R5 divisor zero keeps byte pending
        slv_q[0] = 8'h3C; slv_q[1] = 8'h3C;
        wr(A_TXD, 32'h5A);
        begin
            int lows = 0;
            repeat (300) begin @(negedge clk); if (!cs_n) lows++; end
            check_eq("R5 no start with divisor 0", lows, 0);
        end
        rd(A_STAT, d); check_eq("R5 byte pending", d, 0);
        cs_low = 0;
        wr(A_BAUD, 32'd8);
        wait_frame();
        check_eq("R5 pending byte sent", got[0], 8'h5A);
        check_eq("R5 cs low 72", cs_low, 72);
        rd(A_RXD, d); check_eq("R4 rx after divisor set", d, 8'h3C);

        // R4 R6 random bytes in all four modes
        for (int m = 0; m < 4; m++) begin
            for (int k = 0; k < 3; k++) begin
                int dv;
                dv = 6 + int'($urandom % 7);
                wr(A_BAUD, 32'(dv));
                set_mode(m[1], m[0], 1'b0);
                one_byte(8'($urandom), 8'($urandom), dv, "R4 R6 random");
            end
        end

        // R5 divisor below the floor acts as 6
        wr(A_BAUD, 32'd3);
        one_byte(8'hC3, 8'h81, 6, "R5 floor");

        // R7 loopback ignores miso
        wr(A_BAUD, 32'd7);
        set_mode(1'b1, 1'b1, 1'b1);
        one_byte(8'h6D, 8'hFF, 7, "R7 loop pha1");
        set_mode(1'b0, 1'b0, 1'b1);
        one_byte(8'h92, 8'h00, 7, "R7 loop pha0");

        // R9 chained bytes, R8 overrun
        set_mode(1'b0, 1'b0, 1'b0);
        wr(A_BAUD, 32'd8);
        slv_q[0] = 8'h11; slv_q[1] = 8'hE7;
        cs_low = 0;
        wr(A_TXD, 32'h4B);
        begin
            int n = 0;
            d = 0;
            while (d[1] == 1'b0 && n < 20) begin rd(A_STAT, d); n++; end
        end
        wr(A_TXD, 32'hB4);
        wait_frame();
        check_eq("R9 cs low 17 periods", cs_low, 136);
        check_eq("R9 first byte", got[0], 8'h4B);
        check_eq("R9 second byte", got[1], 8'hB4);
        rd(A_STAT, d); check_eq("R8 overrun raised", d, 32'h23);
        rd(A_RXD, d);  check_eq("R8 newest byte kept", d, 8'hE7);
        rd(A_STAT, d); check_eq("R8 overrun survives read", d, 32'h22);
        wr(A_CTRL, 32'h1 << 2);
        rd(A_STAT, d); check_eq("R8 receiver reset clears", d, 32'h02);

        // R10 interrupt masking
        wr(A_IEN, 32'h02); check_eq("R10 tx ready source", irq, 1);
        wr(A_IEN, 32'h00); check_eq("R10 zero bits keep mask", irq, 1);
        wr(A_IDIS, 32'h02); check_eq("R10 masked", irq, 0);
        wr(A_IEN, 32'h01); check_eq("R10 rx source idle", irq, 0);
        slv_q[0] = 8'h5E; slv_q[1] = 8'h5E;
        wr(A_TXD, 32'h77);
        wait_frame();
        check_eq("R10 irq on rx ready", irq, 1);
        rd(A_RXD, d);
        check_eq("R10 irq drops after read", irq, 0);
        wr(A_IDIS, 32'h01);

        // R11 transmitter reset mid-byte
        wr(A_BAUD, 32'd10);
        wr(A_TXD, 32'hF0);
        begin
            int n = 0;
            while (cs_n && n < 100) begin @(negedge clk); n++; end
        end
        repeat (20) @(negedge clk);
        wr(A_CTRL, 32'h1 << 3);
        check_eq("R11 cs released", cs_n, 1);
        rd(A_STAT, d); check_eq("R11 holding empty, nothing received", d, 32'h02);
        begin
            int lows = 0;
            repeat (200) begin @(negedge clk); if (!cs_n) lows++; end
            check_eq("R11 stays idle", lows, 0);
        end
        one_byte(8'h3A, 8'hA3, 10, "R11 recovered");

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule